// File: doc/BRIEF.md
# Banked Host Aperture Translator

This block sits between the host bus decode and video memory of a display controller. The host sees video memory through a small legacy window in the upper part of its 1 MB address space. The block checks whether a host address falls in the window that is active now. It then works out the byte address in video memory that the access reaches. Reads and writes use the same translation, so one instance serves both directions.

A 2-bit map select picks one of four windows. The 128 KB window at 0xA0000 maps straight through, with no banking. The 64 KB window at 0xA0000 and the two 32 KB windows at 0xB0000 and 0xB8000 are banked. The low 15 bits of the in-window offset are added to one of two programmable bank base registers. Offset bit 15 chooses which register is used.

The result is registered once. Two addresses come out: the raw linear address, and a copy of it cut down to the size of the installed video memory.

Top module: `bank_aperture`

## Requirements
- R1: While `rst_n` is low, `hit`, `lin_addr` and `vram_addr` are all zero.
- R2: With `map_sel` = 2'b00 the window is 0xA0000 to 0xBFFFF. A hit gives `lin_addr` = host address − 0xA0000, with no bank base added.
- R3: With `map_sel` = 2'b01 the window is 0xA0000 to 0xAFFFF. A hit gives `lin_addr` = (offset bit 15 ? `bank1_base` : `bank0_base`) + offset bits 14:0, where offset = host address − 0xA0000.
- R4: With `map_sel` = 2'b10 the window is 0xB0000 to 0xB7FFF. With `map_sel` = 2'b11 it is 0xB8000 to 0xBFFFF. Both windows add the offset to `bank0_base` only.
- R5: A host address outside the active window drives `hit` low, and `lin_addr` and `vram_addr` to zero.
- R6: `vram_addr` is `lin_addr` ANDed with the memory size minus 1. The memory size is `VRAM_MB` megabytes, or 512 KB when `VRAM_MB` is 0.
- R7: Outputs change exactly one clock edge after the inputs. Between edges the outputs do not follow the inputs.
- R8: The bank addition wraps modulo 2^`LIN_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | HOST_W | Host byte address |
| map_sel | input | 2 | Window select (map select field) |
| bank0_base | input | LIN_W | Base of bank 0 in video memory |
| bank1_base | input | LIN_W | Base of bank 1 in video memory |
| lin_addr | output | LIN_W | Translated linear address, registered |
| hit | output | 1 | Host address is inside the active window, registered |
| vram_addr | output | LIN_W | Linear address masked to the memory size, registered |

## Verification
The assertions are checked on every cycle:
- outputs held at zero during reset;
- zeroed outputs on a miss;
- no `vram_addr` bit above the memory size;
- unbanked pass-through for every hit in the 128 KB window;
- a miss for the upper half of the 0xB0000 window.

Only the bench's sweeps can show the following:
- the choice of bank by offset bit 15;
- the exact window edges in all four maps;
- wrap-around of the bank sum;
- the one-cycle latency;
- the 512 KB mask.

The sweeps cover all four maps across 0x9F000 to 0xC1000 on two memory-size builds.

// File: rtl/bank_aperture.sv
module bank_aperture #(
  parameter int HOST_W  = 20,
  parameter int LIN_W   = 24,
  parameter int VRAM_MB = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOST_W-1:0] host_addr,
  input  logic [1:0]        map_sel,
  input  logic [LIN_W-1:0]  bank0_base,
  input  logic [LIN_W-1:0]  bank1_base,
  output logic [LIN_W-1:0]  lin_addr,
  output logic              hit,
  output logic [LIN_W-1:0]  vram_addr
);
  localparam logic [63:0] VRAM_BYTES = (VRAM_MB == 0) ? 64'h80000 : (64'(VRAM_MB) << 20);
  localparam logic [LIN_W-1:0] SIZE_MASK = LIN_W'(VRAM_BYTES - 64'd1);

  logic [HOST_W-1:0] win_base;
  logic [16:0]       win_mask;
  logic              banked;

  always_comb begin
    case (map_sel)
      2'b00:   begin win_base = HOST_W'(20'hA0000); win_mask = 17'h1FFFF; banked = 1'b0; end
      2'b01:   begin win_base = HOST_W'(20'hA0000); win_mask = 17'h0FFFF; banked = 1'b1; end
      2'b10:   begin win_base = HOST_W'(20'hB0000); win_mask = 17'h07FFF; banked = 1'b1; end
      default: begin win_base = HOST_W'(20'hB8000); win_mask = 17'h07FFF; banked = 1'b1; end
    endcase
  end

  wire [HOST_W-1:0] rel    = host_addr - win_base;
  wire              in_win = (rel <= HOST_W'(win_mask));
  wire [16:0]       off    = rel[16:0] & win_mask;
  wire [LIN_W-1:0]  bank_b = off[15] ? bank1_base : bank0_base;
  wire [LIN_W-1:0]  lin_c  = banked ? (bank_b + LIN_W'(off[14:0])) : LIN_W'(off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      lin_addr  <= '0;
      vram_addr <= '0;
    end else begin
      hit       <= in_win;
      lin_addr  <= in_win ? lin_c : '0;
      vram_addr <= in_win ? (lin_c & SIZE_MASK) : '0;
    end
  end
endmodule

module bank_aperture_chk #(
  parameter int HOST_W  = 20,
  parameter int LIN_W   = 24,
  parameter int VRAM_MB = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HOST_W-1:0] host_addr,
  input logic [1:0]        map_sel,
  input logic [LIN_W-1:0]  lin_addr,
  input logic              hit,
  input logic [LIN_W-1:0]  vram_addr
);
  localparam logic [63:0] VRAM_BYTES = (VRAM_MB == 0) ? 64'h80000 : (64'(VRAM_MB) << 20);
  localparam logic [LIN_W-1:0] HIGH_BITS = ~LIN_W'(VRAM_BYTES - 64'd1);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!hit && lin_addr == '0 && vram_addr == '0));

  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (lin_addr == '0 && vram_addr == '0));

  a_r6_within_size: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_addr & HIGH_BITS) == '0);

  a_r2_full_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(map_sel) == 2'b00 && $past(host_addr) >= HOST_W'(20'hA0000)
      && $past(host_addr) <= HOST_W'(20'hBFFFF))
    |-> (hit && lin_addr == LIN_W'($past(host_addr) - HOST_W'(20'hA0000))));

  a_r4_upper_half_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(map_sel) == 2'b10 && $past(host_addr) >= HOST_W'(20'hB8000))
    |-> !hit);
endmodule

bind bank_aperture bank_aperture_chk #(.HOST_W(HOST_W), .LIN_W(LIN_W), .VRAM_MB(VRAM_MB)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .map_sel(map_sel),
  .lin_addr(lin_addr), .hit(hit), .vram_addr(vram_addr)
);

// File: tb/bank_aperture_bench.sv
module bank_aperture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] host_addr = '0;
  logic [1:0]  map_sel = '0;
  logic [23:0] bank0_base = '0, bank1_base = '0;
  logic [23:0] lin_a, vram_a, lin_b, vram_b;
  logic        hit_a, hit_b;
  int tests = 0, fails = 0;
  logic        e_hit;
  logic [23:0] e_lin;

  always #5 clk = ~clk;

  bank_aperture u_bank_aperture (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .map_sel(map_sel),
    .bank0_base(bank0_base), .bank1_base(bank1_base),
    .lin_addr(lin_a), .hit(hit_a), .vram_addr(vram_a));

  bank_aperture #(.VRAM_MB(0)) u_bank_aperture_small (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .map_sel(map_sel),
    .bank0_base(bank0_base), .bank1_base(bank1_base),
    .lin_addr(lin_b), .hit(hit_b), .vram_addr(vram_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h map=%0d actual=%h expected=%h", req, host_addr, map_sel, act, exp);
    end
  endtask

  task automatic expect_of(input logic [19:0] a, input logic [1:0] m);
    longint base, size, off, l;
    case (m)
      2'd0: begin base = 'hA0000; size = 'h20000; end
      2'd1: begin base = 'hA0000; size = 'h10000; end
      2'd2: begin base = 'hB0000; size = 'h8000;  end
      default: begin base = 'hB8000; size = 'h8000; end
    endcase
    e_hit = (longint'(a) >= base) && (longint'(a) < base + size);
    off = longint'(a) - base;
    if (!e_hit) l = 0;
    else if (m == 2'd0) l = off;
    else l = (off[15] ? longint'(bank1_base) : longint'(bank0_base)) + (off % 'h8000);
    e_lin = 24'(l);
  endtask

  task automatic apply(input logic [19:0] a, input logic [1:0] m);
    logic        p_hit;
    logic [23:0] p_lin;
    p_hit = e_hit; p_lin = e_lin;
    @(negedge clk);
    host_addr = a; map_sel = m;
    #1;
    chk("R7 hold", {7'd0, hit_a, p_lin}, {7'd0, p_hit, p_lin});
    chk("R7 hold", lin_a, p_lin);
    expect_of(a, m);
    @(posedge clk); #1;
    chk(m == 0 ? "R2 hit" : (m == 1 ? "R3 hit" : "R4 hit"), hit_a, e_hit);
    chk(e_hit ? (m == 0 ? "R2 lin" : "R3/R4 lin R8") : "R5 miss lin", lin_a, e_lin);
    chk("R6 vram 1MB", vram_a, e_lin & 24'h0FFFFF);
    chk("R5 hit small", hit_b, e_hit);
    chk("R6 vram 512KB", vram_b, e_lin & 24'h07FFFF);
  endtask

  initial begin
    #1;
    chk("R1 hit", hit_a, 0);
    chk("R1 lin", lin_a, 0);
    chk("R1 vram", vram_a, 0);
    host_addr = 20'hA1234;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 held", {hit_a, hit_b}, 0);
    chk("R1 held lin", lin_a, 0);
    @(negedge clk) rst_n = 1'b1;
    expect_of(20'hA1234, 2'd0);
    @(posedge clk); #1;
    for (int s = 0; s < 3; s++) begin
      case (s)
        0: begin bank0_base = 24'h018000; bank1_base = 24'h0F8000; end
        1: begin bank0_base = 24'h123456; bank1_base = 24'h07C001; end
        default: begin bank0_base = 24'hFFC000; bank1_base = 24'hFFFF00; end
      endcase
      for (int m = 0; m < 4; m++) begin
        for (int a = 'h9F000; a < 'hC1000; a += 'h137) apply(20'(a), 2'(m));
        apply(20'h9FFFF, 2'(m)); apply(20'hA0000, 2'(m)); apply(20'hA7FFF, 2'(m));
        apply(20'hA8000, 2'(m)); apply(20'hAFFFF, 2'(m)); apply(20'hB0000, 2'(m));
        apply(20'hB7FFF, 2'(m)); apply(20'hB8000, 2'(m)); apply(20'hBFFFF, 2'(m));
        apply(20'hC0000, 2'(m)); apply(20'h00000, 2'(m)); apply(20'hFFFFF, 2'(m));
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule